// File: doc/BRIEF.md
# Receive Delay Path Mode Sequencer

This block sits between PHY configuration software or firmware and the control registers of a storage-card PHY. It decides how receive data is captured. One choice is a locked DLL. The other is a fixed delay chain that uses a per-mode input tap. It then issues the register writes that put the PHY into the chosen path, strictly in order and one at a time.

A sequence begins when `start_i` is pulsed with a timing-mode code and the bus clock frequency in Hz. At that moment the block latches the mode, the frequency decision and the tap value that the mode selects from the tap table. The DLL is switched off first, whichever path is chosen. Then the TX/RX delay-chain select bits are either cleared (DLL path) or set together (delay-chain path). On the delay-chain path the latched tap value is loaded inside an open/close change-window bracket. After the final acknowledge the block pulses `done_o` for one cycle.

Top module: `rxdly_path_seq`

## Requirements
- R1: The first write of every sequence goes to address 0x100, with mask equal to the DLL enable bit (bit 1) and data 0.
- R2: The DLL path is taken only when the latched mode code is greater than 4 and the latched frequency is at least 50,000,000 Hz. Every other combination takes the delay-chain path.
- R3: On the DLL path the second and final write goes to address 0x110 with mask 0x00030000 and data 0. The sequence is exactly two writes.
- R4: On the delay-chain path the second write goes to address 0x110 with mask 0x00030000 and data 0x00030000. No write in any sequence sets the DLL enable bit.
- R5: On the delay-chain path three writes to address 0x10C follow the second write, in this order: mask and data 0x200 (window open); mask 0x1F with the tap in bits 4:0 (tap load); mask 0x200 with data 0 (window close). The sequence is exactly five writes.
- R6: The loaded tap is entry `mode` of `tap_table_i`, at bits mode*5+4 to mode*5. Mode codes 11 to 15 give tap 0.
- R7: No write to address 0x10C has bit 8 (the tap enable flag) in its mask.
- R8: Only one write is offered at a time. While `wr_valid_o` is high and `wr_ready_i` is low, address, data and mask hold steady.
- R9: `done_o` is high for exactly one cycle, the cycle after the last write is acknowledged. `wr_valid_o` is low in that cycle.
- R10: A start that arrives while a sequence is in progress is ignored. Changes to mode, frequency or table after the start is accepted do not affect the running sequence.
- R11: After reset `wr_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| mode_i | input | 4 | Timing-mode code (0..10 defined) |
| freq_i | input | 32 | Bus clock frequency in Hz |
| tap_table_i | input | 55 | Eleven 5-bit input tap entries, entry i at bits i*5+4:i*5 |
| wr_ready_i | input | 1 | Register port acknowledge |
| wr_valid_o | output | 1 | Register write request |
| wr_addr_o | output | 12 | Register address |
| wr_data_o | output | 32 | Write data (zero outside the mask) |
| wr_mask_o | output | 32 | Bit-enable mask of the write |
| done_o | output | 1 | One-cycle pulse after the last acknowledge |

## Verification
A wrong path decision shows up at the second write of the sequence, one acknowledge after the start. The select data there is 0 or 0x30000 when it should be the other, and the write count is 2 where 5 is expected or the reverse. A step counter that skips or repeats a state breaks the exact write list within the five acknowledges. A tap latched from the wrong entry, or taken live instead of at the start, appears as wrong data in the fourth write. A control state that fails to return to idle shows up as a missing or stretched `done_o` the cycle after the final acknowledge, or as a second start being taken mid-sequence.

// File: rtl/rxdly_pkg.sv
package rxdly_pkg;
  typedef enum logic [2:0] {
    STEP_DLL_OFF   = 3'd0,
    STEP_SEL       = 3'd1,
    STEP_WIN_OPEN  = 3'd2,
    STEP_TAP       = 3'd3,
    STEP_WIN_CLOSE = 3'd4
  } step_t;
endpackage

// File: rtl/rxdly_path_decide.sv
module rxdly_path_decide #(
  parameter int unsigned MODE_W         = 4,
  parameter int unsigned FREQ_W         = 32,
  parameter int unsigned DLL_ABOVE_MODE = 4,
  parameter int unsigned DLL_MIN_FREQ   = 50_000_000
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              use_dll_o
);
  localparam logic [MODE_W-1:0] ModeLim = MODE_W'(DLL_ABOVE_MODE);
  localparam logic [FREQ_W-1:0] FreqLim = FREQ_W'(DLL_MIN_FREQ);

  logic fast_mode, fast_clk;
  assign fast_mode = mode_i > ModeLim;
  assign fast_clk  = freq_i >= FreqLim;
  assign use_dll_o = fast_mode && fast_clk;
endmodule

// File: rtl/rxdly_tap_lookup.sv
module rxdly_tap_lookup #(
  parameter int unsigned NUM_MODES = 11,
  parameter int unsigned MODE_W    = 4,
  parameter int unsigned TAP_W     = 5
) (
  input  logic [NUM_MODES*TAP_W-1:0] table_i,
  input  logic [MODE_W-1:0]          mode_i,
  output logic [TAP_W-1:0]           tap_o
);
  logic [TAP_W-1:0] masked [NUM_MODES];

  for (genvar gi = 0; gi < NUM_MODES; gi++) begin : g_entry
    logic hit;
    assign hit        = mode_i == MODE_W'(gi);
    assign masked[gi] = hit ? table_i[gi*TAP_W +: TAP_W] : '0;
  end

  // unmatched codes fall through to zero
  always_comb begin
    tap_o = '0;
    for (int i = 0; i < NUM_MODES; i++) tap_o = tap_o | masked[i];
  end
endmodule

// File: rtl/rxdly_write_gen.sv
module rxdly_write_gen
  import rxdly_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned TAP_W       = 5,
  parameter logic [ADDR_W-1:0] A_DLL = 12'h100,
  parameter logic [ADDR_W-1:0] A_TAP = 12'h10C,
  parameter logic [ADDR_W-1:0] A_SEL = 12'h110,
  parameter int unsigned DLL_EN_BIT  = 1,
  parameter int unsigned TX_SEL_BIT  = 17,
  parameter int unsigned RX_SEL_BIT  = 16,
  parameter int unsigned WIN_BIT     = 9,
  parameter int unsigned TAP_LSB     = 0
) (
  input  step_t             step_i,
  input  logic              dll_path_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam logic [DATA_W-1:0] MDll = DATA_W'(1) << DLL_EN_BIT;
  localparam logic [DATA_W-1:0] MSel = (DATA_W'(1) << TX_SEL_BIT) | (DATA_W'(1) << RX_SEL_BIT);
  localparam logic [DATA_W-1:0] MWin = DATA_W'(1) << WIN_BIT;
  localparam logic [DATA_W-1:0] MTap = DATA_W'((1 << TAP_W) - 1) << TAP_LSB;

  always_comb begin
    addr_o = A_DLL;
    mask_o = MDll;
    data_o = '0;
    unique case (step_i)
      STEP_DLL_OFF: begin
        addr_o = A_DLL;
        mask_o = MDll;
        data_o = '0;
      end
      STEP_SEL: begin
        addr_o = A_SEL;
        mask_o = MSel;
        data_o = dll_path_i ? '0 : MSel;
      end
      STEP_WIN_OPEN: begin
        addr_o = A_TAP;
        mask_o = MWin;
        data_o = MWin;
      end
      STEP_TAP: begin
        addr_o = A_TAP;
        mask_o = MTap;
        data_o = DATA_W'(tap_i) << TAP_LSB;
      end
      STEP_WIN_CLOSE: begin
        addr_o = A_TAP;
        mask_o = MWin;
        data_o = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxdly_seq_ctrl.sv
module rxdly_seq_ctrl
  import rxdly_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  wr_ready_i,
  input  logic  dll_path_i,
  output logic  accept_o,
  output step_t step_o,
  output logic  wr_valid_o,
  output logic  done_o
);
  step_t step_q;
  logic  active_q, done_q;
  step_t last_step;

  assign accept_o  = start_i && !active_q;
  assign last_step = dll_path_i ? STEP_SEL : STEP_WIN_CLOSE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      step_q   <= STEP_DLL_OFF;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        active_q <= 1'b1;
        step_q   <= STEP_DLL_OFF;
      end else if (active_q && wr_ready_i) begin
        if (step_q == last_step) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          step_q <= step_t'(step_q + 3'd1);
        end
      end
    end
  end

  assign step_o     = step_q;
  assign wr_valid_o = active_q;
  assign done_o     = done_q;
endmodule

// File: rtl/rxdly_path_seq.sv
module rxdly_path_seq
  import rxdly_pkg::*;
#(
  parameter int unsigned NUM_MODES      = 11,
  parameter int unsigned MODE_W         = 4,
  parameter int unsigned FREQ_W         = 32,
  parameter int unsigned TAP_W          = 5,
  parameter int unsigned ADDR_W         = 12,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned DLL_ABOVE_MODE = 4,
  parameter int unsigned DLL_MIN_FREQ   = 50_000_000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic [FREQ_W-1:0]          freq_i,
  input  logic [NUM_MODES*TAP_W-1:0] tap_table_i,
  input  logic                       wr_ready_i,
  output logic                       wr_valid_o,
  output logic [ADDR_W-1:0]          wr_addr_o,
  output logic [DATA_W-1:0]          wr_data_o,
  output logic [DATA_W-1:0]          wr_mask_o,
  output logic                       done_o
);
  logic             use_dll, accept;
  logic [TAP_W-1:0] tap_sel;
  logic             dll_q;
  logic [TAP_W-1:0] tap_q;
  step_t            step;

  rxdly_path_decide #(
    .MODE_W(MODE_W), .FREQ_W(FREQ_W),
    .DLL_ABOVE_MODE(DLL_ABOVE_MODE), .DLL_MIN_FREQ(DLL_MIN_FREQ)
  ) u_decide (
    .mode_i(mode_i), .freq_i(freq_i), .use_dll_o(use_dll)
  );

  rxdly_tap_lookup #(
    .NUM_MODES(NUM_MODES), .MODE_W(MODE_W), .TAP_W(TAP_W)
  ) u_lookup (
    .table_i(tap_table_i), .mode_i(mode_i), .tap_o(tap_sel)
  );

  // operands frozen at accept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_q <= 1'b0;
      tap_q <= '0;
    end else if (accept) begin
      dll_q <= use_dll;
      tap_q <= tap_sel;
    end
  end

  rxdly_seq_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .wr_ready_i(wr_ready_i), .dll_path_i(dll_q),
    .accept_o(accept), .step_o(step),
    .wr_valid_o(wr_valid_o), .done_o(done_o)
  );

  rxdly_write_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAP_W(TAP_W)
  ) u_wgen (
    .step_i(step), .dll_path_i(dll_q), .tap_i(tap_q),
    .addr_o(wr_addr_o), .data_o(wr_data_o), .mask_o(wr_mask_o)
  );
endmodule

// File: rtl/rxdly_path_seq_chk.sv
module rxdly_path_seq_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic [DATA_W-1:0] wr_mask_o,
  input logic              done_o
);
  localparam logic [ADDR_W-1:0] ADll = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] ATap = ADDR_W'(12'h10C);

  p_first_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) |-> (wr_addr_o == ADdll_chk() && wr_mask_o == DATA_W'(2) && wr_data_o == '0));

  p_no_dll_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_addr_o == ADll) |-> !wr_data_o[1]);

  p_tap_flag_untouched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_addr_o == ATap) |-> !wr_mask_o[8]);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_mask_o)));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!wr_valid_o && $past(wr_valid_o) && $past(wr_ready_i)));

  function automatic logic [ADDR_W-1:0] ADdll_chk();
    return ADll;
  endfunction
endmodule

bind rxdly_path_seq rxdly_path_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_mask_o(wr_mask_o), .done_o(done_o)
);

// File: tb/rxdly_path_seq_tb_top.sv
module rxdly_path_seq_tb_top;
  localparam int ClkPeriod = 10;
  localparam int NModes = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [31:0] freq = '0;
  logic [54:0] table_v;
  logic        ready = 1'b1;
  logic        valid, done;
  logic [11:0] addr;
  logic [31:0] data, mask;

  int checks = 0, errors = 0;
  int cyc = 0;
  int stall = 0;
  int nwr = 0;
  int last_wr_cyc = 0, done_cyc = 0, done_cnt = 0;
  logic [11:0] log_a [16];
  logic [31:0] log_d [16];
  logic [31:0] log_m [16];

  always #(ClkPeriod/2) clk = ~clk;

  rxdly_path_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .freq_i(freq),
    .tap_table_i(table_v), .wr_ready_i(ready), .wr_valid_o(valid),
    .wr_addr_o(addr), .wr_data_o(data), .wr_mask_o(mask), .done_o(done)
  );

  function automatic logic [4:0] tap_of(int m);
    return 5'((m * 9 + 5) & 31);
  endfunction

  initial begin
    for (int i = 0; i < NModes; i++) table_v[i*5 +: 5] = tap_of(i);
  end

  always @(posedge clk) begin
    #1;
    ready <= (stall != 0) ? ((cyc % 3) == 0) : 1'b1;
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && valid && ready) begin
      if (nwr < 16) begin
        log_a[nwr] = addr; log_d[nwr] = data; log_m[nwr] = mask;
      end
      nwr = nwr + 1;
      last_wr_cyc = cyc;
    end
    if (rst_n && done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
  end

  initial begin
    #(ClkPeriod * 20000);
    errors = errors + 1;
    $display("FAIL R9 watchdog act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act %h exp %h", req, act, expv);
    end
  endtask

  task automatic check_w(input int i, input string req, input logic [11:0] ea,
                         input logic [31:0] ed, input logic [31:0] em);
    check(log_a[i] == ea, req, 32'(log_a[i]), 32'(ea));
    check(log_m[i] == em, req, log_m[i], em);
    check(log_d[i] == ed, req, log_d[i], ed);
  endtask

  // start one sequence; inputs scrambled right after accept to prove latching (R10)
  task automatic run_seq(input logic [3:0] m, input logic [31:0] f, input bit extra_start);
    nwr = 0; done_cnt = 0;
    @(posedge clk); #1;
    start = 1'b1; mode = m; freq = f;
    @(posedge clk); #1;
    start = 1'b0; mode = ~m; freq = ~f;
    if (extra_start) begin
      @(posedge clk); #1;
      start = 1'b1; mode = 4'd9; freq = 32'd200_000_000;
      @(posedge clk); #1;
      start = 1'b0;
    end
    for (int t = 0; t < 200 && done_cnt == 0; t++) @(posedge clk);
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic expect_seq(input logic [3:0] m, input bit dll, input string req);
    logic [4:0] tap;
    tap = (m < 4'(NModes)) ? tap_of(int'(m)) : 5'd0;
    check(nwr == (dll ? 2 : 5), {req, " count"}, 32'(nwr), dll ? 32'd2 : 32'd5);
    check(done_cnt == 1, "R9 done width", 32'(done_cnt), 32'd1);
    check(done_cyc == last_wr_cyc + 1, "R9 done timing", 32'(done_cyc), 32'(last_wr_cyc + 1));
    if (nwr >= 2) begin
      check_w(0, "R1", 12'h100, 32'h0, 32'h2);
      check_w(1, dll ? "R3" : "R4", 12'h110, dll ? 32'h0 : 32'h30000, 32'h30000);
    end
    if (!dll && nwr == 5) begin
      check_w(2, "R5 open", 12'h10C, 32'h200, 32'h200);
      check_w(3, "R6 tap", 12'h10C, 32'(tap), 32'h1F);
      check_w(4, "R5 close", 12'h10C, 32'h0, 32'h200);
      check(!log_m[2][8] && !log_m[3][8] && !log_m[4][8], "R7", log_m[3], 32'h1F);
    end
  endtask

  task automatic t_reset();
    #1;
    check(valid == 1'b0, "R11 valid", 32'(valid), 32'd0);
    check(done == 1'b0, "R11 done", 32'(done), 32'd0);
  endtask

  task automatic t_chain_legacy();   run_seq(4'd0, 32'd400_000, 0);      expect_seq(4'd0, 0, "R2 legacy"); endtask
  task automatic t_dll_hs200();      run_seq(4'd9, 32'd200_000_000, 0);  expect_seq(4'd9, 1, "R2 hs200"); endtask
  task automatic t_freq_below();     run_seq(4'd6, 32'd49_999_999, 0);   expect_seq(4'd6, 0, "R2 below"); endtask
  task automatic t_freq_exact();     run_seq(4'd5, 32'd50_000_000, 0);   expect_seq(4'd5, 1, "R2 exact"); endtask
  task automatic t_mode_sdr25();     run_seq(4'd4, 32'd200_000_000, 0);  expect_seq(4'd4, 0, "R2 sdr25"); endtask
  task automatic t_last_entry();     run_seq(4'd10, 32'd26_000_000, 0);  expect_seq(4'd10, 0, "R6 last"); endtask
  task automatic t_out_of_range();   run_seq(4'd12, 32'd1_000_000, 0);   expect_seq(4'd12, 0, "R6 range"); endtask
  task automatic t_stall();
    stall = 1;
    run_seq(4'd3, 32'd25_000_000, 0);
    expect_seq(4'd3, 0, "R8 stall");
    run_seq(4'd7, 32'd50_000_000, 0);
    expect_seq(4'd7, 1, "R8 stall dll");
    stall = 0;
  endtask
  task automatic t_ignore_start();   run_seq(4'd1, 32'd52_000_000, 1);   expect_seq(4'd1, 0, "R10 ignore"); endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_chain_legacy();
    t_dll_hs200();
    t_freq_below();
    t_freq_exact();
    t_mode_sdr25();
    t_last_entry();
    t_out_of_range();
    t_stall();
    t_ignore_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule